// File: doc/BRIEF.md
# Interrupt Request Capture and Acknowledge Resolution

This block is the front end of an eight-line interrupt controller. It turns raw request lines into pending bits and, when the processor acknowledges, picks the winning line. It also keeps track of which levels are being serviced. One configuration input chooses how all lines are sensed. In edge mode a line raises a request once per low-to-high transition. In level mode a line requests for as long as it is high.

An acknowledge strobe marks the first acknowledge pulse. At that moment the block looks at the lines that are pending, unmasked and still high. The lowest-numbered such line wins, its pending bit is cleared and its in-service bit is set. The winning level is reported one clock later. If no line qualifies, the request has vanished, for example a noise glitch. The block then reports a default level of 7, raises a default flag and leaves the in-service register untouched. Software can therefore tell a spurious level-7 acknowledge from a real one by looking at in-service bit 7. A non-specific end-of-interrupt pulse retires the highest-priority level in service.

Top module: `irq_front`

## Requirements
- R1: After reset, `pending_o`, `inservice_o`, `ack_valid_o`, `ack_default_o` and `irq_o` are all zero.
- R2: With `level_mode_i`=0, a line sampled low on one clock edge and high on the next sets its `pending_o` bit at that second edge.
- R3: With `level_mode_i`=0, a pending bit clears at the first clock edge where its line is sampled low. A line held high raises no new request after it has been acknowledged, until it is sampled low and then high again.
- R4: With `level_mode_i`=1, each `pending_o` bit equals its line as sampled at the previous clock edge. The exception is the winning bit: it reads 0 for the one cycle after the acknowledge, and then follows the line again.
- R5: A one-cycle `ack_i` makes `ack_valid_o` high for exactly the next cycle. `ack_level_o` then gives the index of the lowest-numbered line that was pending, unmasked and high when `ack_i` was sampled (bit 0 is the highest priority). That line's pending bit is cleared and its in-service bit is set.
- R6: If no line qualifies at `ack_i`, `ack_level_o` reads 7 and `ack_default_o` reads 1, and no in-service bit is set. This includes a line that drops in the very cycle of `ack_i`.
- R7: An `eoi_i` pulse clears the lowest-numbered set bit of `inservice_o`. If no bit is set, it has no effect.
- R8: A line whose `mask_i` bit is 1 never wins an acknowledge. `irq_o` is high exactly when some pending bit is unmasked.
- R9: A genuine level-7 acknowledge reports level 7 with `ack_default_o`=0 and sets `inservice_o` bit 7.
- R10: When `eoi_i` and `ack_i` fall in the same cycle, the end-of-interrupt acts on the in-service value held before that edge. The new winner's bit is set in addition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 8 | Interrupt request lines, bit 0 highest priority |
| level_mode_i | input | 1 | 1 = level sensing, 0 = edge sensing |
| mask_i | input | 8 | Per-line mask, 1 = excluded |
| ack_i | input | 1 | One-cycle strobe for the first acknowledge pulse |
| eoi_i | input | 1 | One-cycle non-specific end-of-interrupt |
| irq_o | output | 1 | Some unmasked request is pending |
| pending_o | output | 8 | Pending request bits |
| inservice_o | output | 8 | In-service bits |
| ack_valid_o | output | 1 | Acknowledge result valid (one cycle) |
| ack_level_o | output | 3 | Resolved level |
| ack_default_o | output | 1 | Result is the default level (no genuine request) |

## Verification
Two functions can fall in the same clock: the end-of-interrupt that retires a level, and an acknowledge that sets a new in-service bit. The bench provokes this by holding level 7 in service and asserting `eoi_i` and `ack_i` together while line 2 is requesting. It expects bit 7 to be gone and bit 2 to be set. A second collision comes from dropping a line in the same cycle as `ack_i`. That pairs request withdrawal with resolution, and it is judged by the default-level response and an unchanged in-service register.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int unsigned N_IRQ = 8;
  localparam int unsigned LVL_W = $clog2(N_IRQ);
  typedef logic [N_IRQ-1:0] irq_vec_t;
  typedef logic [LVL_W-1:0] irq_lvl_t;
  localparam irq_lvl_t DEFAULT_LVL = irq_lvl_t'(N_IRQ - 1);

  // Keep only the lowest-numbered set bit (highest priority).
  function automatic irq_vec_t lowest_onehot(irq_vec_t v);
    irq_vec_t r;
    logic     found;
    r     = '0;
    found = 1'b0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (v[i] && !found) begin
        r[i]  = 1'b1;
        found = 1'b1;
      end
    end
    return r;
  endfunction

  // Encode a one-hot vector into its bit index.
  function automatic irq_lvl_t onehot_to_lvl(irq_vec_t oh);
    irq_lvl_t l;
    l = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      if (oh[i]) l = l | irq_lvl_t'(i);
    end
    return l;
  endfunction
endpackage

// File: rtl/irqf_sense.sv
module irqf_sense
  import irqf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t req_i,
  input  logic     level_mode_i,
  input  irq_vec_t clr_i,
  output irq_vec_t rise_o,
  output irq_vec_t pending_o
);
  irq_vec_t armed_q;
  irq_vec_t pend_q;

  for (genvar g = 0; g < N_IRQ; g++) begin : g_line
    logic nxt;
    assign rise_o[g] = req_i[g] & armed_q[g];
    always_comb begin
      if (level_mode_i) nxt = req_i[g];
      else              nxt = (pend_q[g] | rise_o[g]) & req_i[g];
      nxt = nxt & ~clr_i[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        armed_q[g] <= 1'b0;
        pend_q[g]  <= 1'b0;
      end else begin
        armed_q[g] <= ~req_i[g];
        pend_q[g]  <= nxt;
      end
    end
  end

  assign pending_o = pend_q;
endmodule

// File: rtl/irqf_resolve.sv
module irqf_resolve
  import irqf_pkg::*;
(
  input  irq_vec_t pending_i,
  input  irq_vec_t req_i,
  input  irq_vec_t mask_i,
  input  logic     ack_i,
  output irq_vec_t win_onehot_o,
  output irq_lvl_t win_lvl_o,
  output logic     dflt_o,
  output logic     irq_o
);
  irq_vec_t cand;
  irq_vec_t first;

  assign cand         = pending_i & req_i & ~mask_i;
  assign first        = lowest_onehot(cand);
  assign dflt_o       = (cand == '0);
  assign win_lvl_o    = dflt_o ? DEFAULT_LVL : onehot_to_lvl(first);
  assign win_onehot_o = ack_i ? first : '0;
  assign irq_o        = |(pending_i & ~mask_i);
endmodule

// File: rtl/irqf_service.sv
module irqf_service
  import irqf_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  irq_vec_t set_i,
  input  logic     eoi_i,
  output irq_vec_t eoi_clr_o,
  output irq_vec_t isr_o
);
  irq_vec_t isr_q;

  assign eoi_clr_o = eoi_i ? lowest_onehot(isr_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) isr_q <= '0;
    else        isr_q <= (isr_q & ~eoi_clr_o) | set_i;
  end

  assign isr_o = isr_q;
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irqf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IRQ-1:0] req_i,
  input  logic             level_mode_i,
  input  logic [N_IRQ-1:0] mask_i,
  input  logic             ack_i,
  input  logic             eoi_i,
  output logic             irq_o,
  output logic [N_IRQ-1:0] pending_o,
  output logic [N_IRQ-1:0] inservice_o,
  output logic             ack_valid_o,
  output logic [LVL_W-1:0] ack_level_o,
  output logic             ack_default_o
);
  irq_vec_t rise;
  irq_vec_t win_onehot;
  irq_vec_t eoi_clr;
  irq_lvl_t win_lvl;
  logic     win_dflt;

  irqf_sense u_sense (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .level_mode_i(level_mode_i),
    .clr_i(win_onehot), .rise_o(rise), .pending_o(pending_o)
  );

  irqf_resolve u_resolve (
    .pending_i(pending_o), .req_i(req_i), .mask_i(mask_i), .ack_i(ack_i),
    .win_onehot_o(win_onehot), .win_lvl_o(win_lvl), .dflt_o(win_dflt),
    .irq_o(irq_o)
  );

  irqf_service u_service (
    .clk(clk), .rst_n(rst_n), .set_i(win_onehot), .eoi_i(eoi_i),
    .eoi_clr_o(eoi_clr), .isr_o(inservice_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_valid_o   <= 1'b0;
      ack_level_o   <= '0;
      ack_default_o <= 1'b0;
    end else begin
      ack_valid_o   <= ack_i;
      ack_level_o   <= ack_i ? win_lvl : ack_level_o;
      ack_default_o <= ack_i & win_dflt;
    end
  end
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk
  import irqf_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input irq_vec_t req_i,
  input logic     level_mode_i,
  input irq_vec_t mask_i,
  input logic     ack_i,
  input logic     eoi_i,
  input irq_vec_t pending_o,
  input irq_vec_t inservice_o,
  input logic     ack_valid_o,
  input irq_lvl_t ack_level_o,
  input logic     ack_default_o,
  input irq_vec_t win_onehot,
  input irq_vec_t eoi_clr
);
  logic     live_q;
  irq_vec_t mask_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q    <= 1'b0;
      mask_prev <= '0;
    end else begin
      live_q    <= 1'b1;
      mask_prev <= mask_i;
    end
  end

  assert_ack_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ack_i |=> ack_valid_o);
  assert_ack_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_i |=> !ack_valid_o);
  assert_win_in_service_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_valid_o && !ack_default_o) |-> inservice_o[ack_level_o]);
  assert_default_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ack_default_o |-> (ack_valid_o && ack_level_o == DEFAULT_LVL));
  assert_default_keeps_isr_R6: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (ack_default_o && !$past(eoi_i)) |-> inservice_o == $past(inservice_o));
  assert_pending_needs_line_R3: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (pending_o & ~$past(req_i)) == '0);
  assert_level_follows_R4: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    $past(level_mode_i) |-> pending_o == ($past(req_i) & ~$past(win_onehot)));
  assert_eoi_retires_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !ack_i && inservice_o != '0) |=>
      $countones(inservice_o) == $countones($past(inservice_o)) - 1);
  assert_eoi_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eoi_clr));
  assert_mask_excludes_R8: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
    (ack_valid_o && !ack_default_o) |-> !mask_prev[ack_level_o]);
endmodule

bind irq_front irq_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .level_mode_i(level_mode_i),
  .mask_i(mask_i), .ack_i(ack_i), .eoi_i(eoi_i), .pending_o(pending_o),
  .inservice_o(inservice_o), .ack_valid_o(ack_valid_o),
  .ack_level_o(ack_level_o), .ack_default_o(ack_default_o),
  .win_onehot(win_onehot), .eoi_clr(eoi_clr)
);

// File: tb/irq_front_bench.sv
module irq_front_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_i = '0;
  logic       level_mode_i = 1'b0;
  logic [7:0] mask_i = '0;
  logic       ack_i = 1'b0;
  logic       eoi_i = 1'b0;
  logic       irq_o;
  logic [7:0] pending_o;
  logic [7:0] inservice_o;
  logic       ack_valid_o;
  logic [2:0] ack_level_o;
  logic       ack_default_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  irq_front u_irq_front (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .level_mode_i(level_mode_i),
    .mask_i(mask_i), .ack_i(ack_i), .eoi_i(eoi_i), .irq_o(irq_o),
    .pending_o(pending_o), .inservice_o(inservice_o),
    .ack_valid_o(ack_valid_o), .ack_level_o(ack_level_o),
    .ack_default_o(ack_default_o)
  );

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_ack();
    ack_i = 1'b1; tick(); ack_i = 1'b0;
  endtask

  task automatic do_eoi();
    eoi_i = 1'b1; tick(); eoi_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pending", pending_o, 8'h00);
    chk("R1 inservice", inservice_o, 8'h00);
    chk("R1 ack_valid", ack_valid_o, 0);
    chk("R1 default", ack_default_o, 0);
    chk("R1 irq", irq_o, 0);
  endtask

  task automatic t_edge();
    level_mode_i = 1'b0;
    req_i = 8'h08; tick();
    chk("R2 edge pending", pending_o, 8'h08);
    chk("R8 irq on pending", irq_o, 1);
    do_ack();
    chk("R5 valid", ack_valid_o, 1);
    chk("R5 level", ack_level_o, 3);
    chk("R5 not default", ack_default_o, 0);
    chk("R5 isr set", inservice_o, 8'h08);
    chk("R5 pending cleared", pending_o, 8'h00);
    tick();
    chk("R5 valid one cycle", ack_valid_o, 0);
    tick(); tick();
    chk("R3 no retrigger while high", pending_o, 8'h00);
    do_eoi();
    chk("R7 eoi clears", inservice_o, 8'h00);
    req_i = 8'h00; tick();
    req_i = 8'h08; tick();
    chk("R2 re-armed edge", pending_o, 8'h08);
    req_i = 8'h00; tick();
    chk("R3 pending drops with line", pending_o, 8'h00);
    do_ack();
    chk("R6 default level", ack_level_o, 7);
    chk("R6 default flag", ack_default_o, 1);
    chk("R6 isr unchanged", inservice_o, 8'h00);
  endtask

  task automatic t_level();
    level_mode_i = 1'b1;
    req_i = 8'h20; tick();
    chk("R4 level pending", pending_o, 8'h20);
    do_ack();
    chk("R5 level win", ack_level_o, 5);
    chk("R4 cleared one cycle", pending_o, 8'h00);
    chk("R5 isr bit5", inservice_o, 8'h20);
    tick();
    chk("R4 reasserts while high", pending_o, 8'h20);
    req_i = 8'h00; tick();
    chk("R4 follows line low", pending_o, 8'h00);
    do_eoi();
    chk("R7 eoi level", inservice_o, 8'h00);
  endtask

  task automatic t_mask();
    level_mode_i = 1'b1;
    req_i = 8'h24; mask_i = 8'h04; tick();
    chk("R8 irq with unmasked", irq_o, 1);
    do_ack();
    chk("R8 masked line skipped", ack_level_o, 5);
    chk("R8 isr", inservice_o, 8'h20);
    req_i = 8'h04; tick(); tick();
    chk("R8 irq only masked", irq_o, 0);
    req_i = 8'h00; mask_i = 8'h00;
    do_eoi();
    chk("R7 eoi after mask", inservice_o, 8'h00);
  endtask

  task automatic t_glitch();
    level_mode_i = 1'b1;
    req_i = 8'h02; tick();
    chk("R4 pending line1", pending_o, 8'h02);
    req_i = 8'h00; ack_i = 1'b1; tick(); ack_i = 1'b0;
    chk("R6 drop at ack level", ack_level_o, 7);
    chk("R6 drop at ack flag", ack_default_o, 1);
    chk("R6 drop at ack isr", inservice_o, 8'h00);
  endtask

  task automatic t_real7();
    level_mode_i = 1'b1;
    req_i = 8'h80; tick();
    do_ack();
    req_i = 8'h00;
    chk("R9 level7", ack_level_o, 7);
    chk("R9 not default", ack_default_o, 0);
    chk("R9 isr7", inservice_o, 8'h80);
  endtask

  task automatic t_collide();
    req_i = 8'h04; tick();
    ack_i = 1'b1; eoi_i = 1'b1; tick(); ack_i = 1'b0; eoi_i = 1'b0;
    req_i = 8'h00;
    chk("R10 eoi then ack", inservice_o, 8'h04);
    chk("R10 level", ack_level_o, 2);
    req_i = 8'h20; tick();
    do_ack();
    req_i = 8'h00;
    chk("R7 two in service", inservice_o, 8'h24);
    do_eoi();
    chk("R7 highest priority retired", inservice_o, 8'h20);
    do_eoi();
    do_eoi();
    chk("R7 eoi on empty", inservice_o, 8'h00);
  endtask

  initial begin
    tick(); tick();
    t_reset();
    rst_n = 1'b1;
    tick(); tick();
    t_edge();
    t_level();
    t_mask();
    t_glitch();
    t_real7();
    t_collide();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule